// File: doc/BRIEF.md
# Low-Power Standby Mode Controller

This block decides what happens to the chip when the CPU executes a sleep instruction. An 8-bit control register sits on a simple register bus. It holds three settings. The first picks between a light sleep and a deep software standby. The second chooses whether the I/O pins float while in standby. The third masks external interrupts as a way out of standby.

A small state machine moves between RUN, SLEEP and STANDBY and drives the control outputs: CPU halt, clock stop and port high-impedance enable. These outputs go to the clock generator, the CPU core and the pad ring.

The watchdog timer's enable bit arrives as an input. While the watchdog runs, any write that tries to set the standby-select bit or the pin-float bit is refused for that bit. This stops the chip from dropping into a clockless state with a live watchdog. Wake-up comes from a rising edge on any of the external interrupt request lines.

Top module: `stby_ctrl`

## Requirements
- R1: After reset, the state is RUN (code 0), cpu_halt_o, clk_stop_o and port_hiz_o are low, and the register reads 8'h1F.
- R2: A write with bus_addr_i equal to REG_ADDR updates the register, and bus_rdata_o returns the register whenever bus_addr_i equals REG_ADDR, else 0. The fields are: bit 7 selects standby (1) or sleep (0), bit 6 enables pin high-impedance in standby, and bit 0 disables interrupt wake from standby.
- R3: Bit 5 always reads 0 and bits 4..1 always read 1, whatever value was written.
- R4: In RUN, a high sleep_req_i moves the state to SLEEP (code 1) when bit 7 is 0, or to STANDBY (code 2) when bit 7 is 1, at the next clock edge.
- R5: While wdt_run_i is 1, a write with bit 7 = 1 leaves bit 7 unchanged. A write with bit 7 = 0 always clears it.
- R6: While wdt_run_i is 1, a write with bit 6 = 1 leaves bit 6 unchanged. A write with bit 6 = 0 always clears it.
- R7: port_hiz_o is high only in STANDBY with bit 6 = 1. It is low in STANDBY with bit 6 = 0 (pins keep their state) and in every other state.
- R8: In STANDBY, a rising edge on any irq_i line returns the state to RUN at the next clock edge when bit 0 is 0. When bit 0 is 1, the state stays in STANDBY.
- R9: In SLEEP, a rising edge on any irq_i line returns the state to RUN at the next clock edge, whatever the value of bit 0.
- R10: cpu_halt_o is high in SLEEP and in STANDBY. clk_stop_o is high only in STANDBY.
- R11: An irq_i line held high wakes nothing. Only a low-to-high transition counts, and edges that occur in RUN are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | ADDR_W | Register bus address |
| bus_we_i | input | 1 | Register bus write strobe |
| bus_wdata_i | input | 8 | Register bus write data |
| bus_rdata_o | output | 8 | Register bus read data |
| wdt_run_i | input | 1 | Watchdog timer enable, locks bits 7 and 6 against being set |
| sleep_req_i | input | 1 | CPU executes sleep instruction |
| irq_i | input | NUM_IRQ | External interrupt request lines |
| state_o | output | 2 | Power state: 0 RUN, 1 SLEEP, 2 STANDBY |
| cpu_halt_o | output | 1 | Halt CPU core |
| clk_stop_o | output | 1 | Stop clocks |
| port_hiz_o | output | 1 | Float I/O pins |

## Verification
The bench builds the block with ADDR_W = 2, REG_ADDR = 1 and NUM_IRQ = 4. This setting leaves other addresses free, so the test can show that a write to a non-matching address is dropped and that reads there return zero. It also drives each of the four interrupt lines separately, which shows that every line can wake the block and that a held level cannot.

// File: rtl/stby_pkg.sv
package stby_pkg;
  localparam int REG_W = 8;
  localparam int BIT_SSBY = 7;
  localparam int BIT_HIZ  = 6;
  localparam int BIT_WDIS = 0;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_SLEEP = 2'd1,
    ST_STBY  = 2'd2
  } pm_state_e;
endpackage

// File: rtl/stby_reg.sv
module stby_reg
  import stby_pkg::*;
#(
  parameter int ADDR_W   = 2,
  parameter int REG_ADDR = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic              wdt_run_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic              ssby_o,
  output logic              hiz_o,
  output logic              wdis_o
);
  localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(REG_ADDR);

  logic hit, wr;
  logic ssby_q, hiz_q, wdis_q;
  logic [REG_W-1:0] reg_val;
  logic unused_wbits;

  assign hit = (addr_i == HIT_ADDR);
  assign wr  = we_i & hit;
  assign unused_wbits = ^wdata_i[5:1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ssby_q <= 1'b0;
      hiz_q  <= 1'b0;
      wdis_q <= 1'b1;
    end else if (wr) begin
      // setting is refused while watchdog runs; clearing always allowed
      if (!(wdata_i[BIT_SSBY] && wdt_run_i)) ssby_q <= wdata_i[BIT_SSBY];
      if (!(wdata_i[BIT_HIZ]  && wdt_run_i)) hiz_q  <= wdata_i[BIT_HIZ];
      wdis_q <= wdata_i[BIT_WDIS];
    end
  end

  assign reg_val = {ssby_q, hiz_q, 1'b0, 4'hF, wdis_q};
  assign rdata_o = hit ? reg_val : '0;
  assign ssby_o  = ssby_q;
  assign hiz_o   = hiz_q;
  assign wdis_o  = wdis_q;
endmodule

// File: rtl/stby_edge.sv
module stby_edge #(
  parameter int NUM_IRQ = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_IRQ-1:0] irq_i,
  output logic               rise_o
);
  logic [NUM_IRQ-1:0] irq_q;
  logic [NUM_IRQ-1:0] rise;

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_line
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) irq_q[g] <= 1'b0;
      else         irq_q[g] <= irq_i[g];
    end
    assign rise[g] = irq_i[g] & ~irq_q[g];
  end

  assign rise_o = |rise;
endmodule

// File: rtl/stby_fsm.sv
module stby_fsm
  import stby_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      sleep_req_i,
  input  logic      ssby_i,
  input  logic      hiz_i,
  input  logic      wdis_i,
  input  logic      wake_i,
  output pm_state_e state_o,
  output logic      halt_o,
  output logic      stop_o,
  output logic      hiz_o
);
  pm_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:   if (sleep_req_i) state_d = ssby_i ? ST_STBY : ST_SLEEP;
      ST_SLEEP: if (wake_i) state_d = ST_RUN;
      ST_STBY:  if (wake_i && !wdis_i) state_d = ST_RUN;
      default:  state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_RUN;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
  assign halt_o  = (state_q != ST_RUN);
  assign stop_o  = (state_q == ST_STBY);
  assign hiz_o   = (state_q == ST_STBY) & hiz_i;
endmodule

// File: rtl/stby_ctrl.sv
module stby_ctrl
  import stby_pkg::*;
#(
  parameter int ADDR_W   = 2,
  parameter int REG_ADDR = 0,
  parameter int NUM_IRQ  = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic               bus_we_i,
  input  logic [7:0]         bus_wdata_i,
  output logic [7:0]         bus_rdata_o,
  input  logic               wdt_run_i,
  input  logic               sleep_req_i,
  input  logic [NUM_IRQ-1:0] irq_i,
  output logic [1:0]         state_o,
  output logic               cpu_halt_o,
  output logic               clk_stop_o,
  output logic               port_hiz_o
);
  logic ssby, hiz_en, wdis, wake;
  pm_state_e st;

  stby_reg #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_reg (
    .clk_i, .rst_ni,
    .addr_i(bus_addr_i), .we_i(bus_we_i), .wdata_i(bus_wdata_i),
    .wdt_run_i, .rdata_o(bus_rdata_o),
    .ssby_o(ssby), .hiz_o(hiz_en), .wdis_o(wdis)
  );

  stby_edge #(.NUM_IRQ(NUM_IRQ)) u_edge (
    .clk_i, .rst_ni, .irq_i, .rise_o(wake)
  );

  stby_fsm u_fsm (
    .clk_i, .rst_ni, .sleep_req_i,
    .ssby_i(ssby), .hiz_i(hiz_en), .wdis_i(wdis), .wake_i(wake),
    .state_o(st), .halt_o(cpu_halt_o), .stop_o(clk_stop_o), .hiz_o(port_hiz_o)
  );

  assign state_o = st;
endmodule

// File: rtl/stby_ctrl_chk.sv
module stby_ctrl_chk
  import stby_pkg::*;
#(
  parameter int ADDR_W   = 2,
  parameter int REG_ADDR = 0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic              bus_we_i,
  input logic [7:0]        bus_wdata_i,
  input logic [7:0]        bus_rdata_o,
  input logic              wdt_run_i,
  input logic              sleep_req_i,
  input logic [1:0]        state_o,
  input logic              cpu_halt_o,
  input logic              clk_stop_o,
  input logic              port_hiz_o,
  input logic              ssby,
  input logic              hiz_en,
  input logic              wdis,
  input logic              wake
);
  logic wr;
  assign wr = bus_we_i && (bus_addr_i == ADDR_W'(REG_ADDR));

  AST_RESERVED_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_addr_i == ADDR_W'(REG_ADDR)) |-> (bus_rdata_o[5:1] == 5'b01111)); // R3
  AST_SSBY_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && wdt_run_i && !ssby) |=> !ssby); // R5
  AST_HIZ_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && wdt_run_i && !hiz_en) |=> !hiz_en); // R6
  AST_STBY_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_RUN && sleep_req_i && ssby) |=> (state_o == ST_STBY)); // R4
  AST_SLEEP_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_RUN && sleep_req_i && !ssby) |=> (state_o == ST_SLEEP)); // R4
  AST_HIZ_ONLY_STBY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    port_hiz_o |-> clk_stop_o); // R7
  AST_STOP_HALTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_stop_o |-> cpu_halt_o); // R10
  AST_STBY_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_STBY && wdis) |=> (state_o == ST_STBY)); // R8
  AST_STBY_WAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_STBY && !wdis && wake) |=> (state_o == ST_RUN)); // R8
  AST_SLEEP_WAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_SLEEP && wake) |=> (state_o == ST_RUN)); // R9
endmodule

bind stby_ctrl stby_ctrl_chk #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_chk (
  .clk_i, .rst_ni, .bus_addr_i, .bus_we_i, .bus_wdata_i, .bus_rdata_o,
  .wdt_run_i, .sleep_req_i, .state_o, .cpu_halt_o, .clk_stop_o, .port_hiz_o,
  .ssby, .hiz_en, .wdis, .wake
);

// File: tb/stby_ctrl_test.sv
module stby_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 2;
  localparam int REG_ADDR = 1;
  localparam int NUM_IRQ = 4;
  localparam logic [ADDR_W-1:0] A = ADDR_W'(REG_ADDR);

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [ADDR_W-1:0] bus_addr_i = A;
  logic bus_we_i = 1'b0;
  logic [7:0] bus_wdata_i = '0;
  logic [7:0] bus_rdata_o;
  logic wdt_run_i = 1'b0;
  logic sleep_req_i = 1'b0;
  logic [NUM_IRQ-1:0] irq_i = '0;
  logic [1:0] state_o;
  logic cpu_halt_o, clk_stop_o, port_hiz_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  typedef struct {
    logic [1:0] st;
    logic       hiz;
    logic [7:0] rd;
    string      tag;
  } exp_t;
  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  stby_ctrl #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR), .NUM_IRQ(NUM_IRQ)) uut (
    .clk_i(clk), .rst_ni, .bus_addr_i, .bus_we_i, .bus_wdata_i, .bus_rdata_o,
    .wdt_run_i, .sleep_req_i, .irq_i, .state_o, .cpu_halt_o, .clk_stop_o, .port_hiz_o
  );

  task automatic compare(input exp_t e);
    logic eh, es;
    eh = (e.st != 2'd0);
    es = (e.st == 2'd2);
    total++;
    if (state_o !== e.st || cpu_halt_o !== eh || clk_stop_o !== es ||
        port_hiz_o !== e.hiz || bus_rdata_o !== e.rd) begin
      bad++;
      $display("FAIL %s: st=%0d/%0d halt=%0b/%0b stop=%0b/%0b hiz=%0b/%0b rd=%h/%h (act/exp)",
               e.tag, state_o, e.st, cpu_halt_o, eh, clk_stop_o, es,
               port_hiz_o, e.hiz, bus_rdata_o, e.rd);
    end
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      while (q.size() > 0) compare(q.pop_front());
    end
  end

  // driver: apply one cycle of stimulus, queue expected result after the edge
  task automatic cyc(input logic [ADDR_W-1:0] ad, input logic we, input logic [7:0] wd,
                     input logic wdt, input logic slp, input logic [NUM_IRQ-1:0] irq,
                     input logic [1:0] est, input logic ehiz, input logic [7:0] erd,
                     input string tag);
    exp_t e;
    bus_addr_i = ad; bus_we_i = we; bus_wdata_i = wd;
    wdt_run_i = wdt; sleep_req_i = slp; irq_i = irq;
    @(posedge clk);
    e.st = est; e.hiz = ehiz; e.rd = erd; e.tag = tag;
    q.push_back(e);
    @(negedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: act=timeout exp=completion");
    finish_run();
  end

  initial begin
    exp_t e;
    repeat (2) @(negedge clk);
    e.st = 2'd0; e.hiz = 1'b0; e.rd = 8'h1F; e.tag = "R1 reset";
    compare(e);
    #1 rst_ni = 1'b1;
    @(negedge clk); #1;

    cyc(A, 1, 8'h20, 0, 0, 4'b0000, 0, 0, 8'h1E, "R3 reserved");
    cyc(A, 0, 8'h00, 0, 1, 4'b0000, 1, 0, 8'h1E, "R4 sleep entry");
    cyc(A, 0, 8'h00, 0, 0, 4'b0000, 1, 0, 8'h1E, "R10 sleep holds");
    cyc(A, 0, 8'h00, 0, 0, 4'b0100, 0, 0, 8'h1E, "R9 sleep wake");
    cyc(A, 0, 8'h00, 0, 1, 4'b0100, 1, 0, 8'h1E, "R4 sleep again");
    cyc(A, 0, 8'h00, 0, 0, 4'b0100, 1, 0, 8'h1E, "R11 level held");
    cyc(A, 0, 8'h00, 0, 0, 4'b0000, 1, 0, 8'h1E, "R11 falling");
    cyc(A, 0, 8'h00, 0, 0, 4'b0001, 0, 0, 8'h1E, "R9 wake irq0");
    cyc(A, 1, 8'h80, 1, 0, 4'b0000, 0, 0, 8'h1E, "R5 set refused");
    cyc(A, 1, 8'h40, 1, 0, 4'b0000, 0, 0, 8'h1E, "R6 set refused");
    cyc(A, 1, 8'hC0, 0, 0, 4'b0000, 0, 0, 8'hDE, "R2 write");
    cyc(A, 1, 8'hC1, 1, 0, 4'b0000, 0, 0, 8'hDF, "R5 already set kept");
    cyc(A, 1, 8'h01, 1, 0, 4'b0000, 0, 0, 8'h1F, "R6 clear while locked");
    cyc(A, 1, 8'hC0, 0, 0, 4'b0000, 0, 0, 8'hDE, "R2 write");
    cyc(A, 0, 8'h00, 0, 1, 4'b0000, 2, 1, 8'hDE, "R7 standby hiz");
    cyc(A, 0, 8'h00, 0, 0, 4'b0000, 2, 1, 8'hDE, "R10 standby holds");
    cyc(A, 0, 8'h00, 0, 0, 4'b0010, 0, 0, 8'hDE, "R8 standby wake");
    cyc(A, 1, 8'h81, 0, 0, 4'b0000, 0, 0, 8'h9F, "R2 write");
    cyc(A, 0, 8'h00, 0, 1, 4'b0000, 2, 0, 8'h9F, "R7 pins kept");
    cyc(A, 0, 8'h00, 0, 0, 4'b1000, 2, 0, 8'h9F, "R8 wake masked");
    cyc(A, 1, 8'h80, 0, 0, 4'b0000, 2, 0, 8'h9E, "R8 unmask");
    cyc(A, 0, 8'h00, 0, 0, 4'b1000, 0, 0, 8'h9E, "R8 wake irq3");
    cyc(2'd2, 1, 8'h00, 0, 0, 4'b0000, 0, 0, 8'h00, "R2 other addr");
    cyc(A, 0, 8'h00, 0, 0, 4'b0000, 0, 0, 8'h9E, "R2 miss ignored");
    cyc(A, 0, 8'h00, 0, 1, 4'b0001, 2, 0, 8'h9E, "R11 edge in run ignored");
    cyc(A, 0, 8'h00, 0, 0, 4'b0001, 2, 0, 8'h9E, "R11 level in standby");
    cyc(A, 0, 8'h00, 0, 0, 4'b0000, 2, 0, 8'h9E, "R11 low");
    cyc(A, 0, 8'h00, 0, 0, 4'b0001, 0, 0, 8'h9E, "R8 wake irq0");

    @(negedge clk); #1;
    finish_run();
  end
endmodule